// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of taking an exception in a 32-bit pipeline with one branch delay slot. A single request arrives with a cause code, a TLB-refill qualifier, a faulting virtual address and a coprocessor number, together with the current and next program counters of the faulting instruction. In the cycle the request is accepted, the block updates its status, cause, exception-PC, bad-address and shadow-set control registers. It also selects the handler address and drives a one-cycle redirect carrying the handler address and the two sequential addresses after it.

The handler is chosen from the pre-entry exception level, the boot-vector flag and the interrupt-vector flag. A delay-slot instruction is detected because its next PC is not its own PC plus 4, and EPC then points back at the branch. The shadow register set fields rotate only when the block was running at normal level with normal vectors. Software reaches all six registers through a simple write port and a combinational read port.

Top module: `exc_entry_ctrl`

Register indexes on `sw_addr`: 0 status, 1 cause, 2 EPC, 3 bad address, 4 shadow-set control, 5 exception base. Status fields: EXL bit 1, BEV bit 22, CU1 bit 29. Cause fields: code [6:2], IV bit 23, CE [29:28], BD bit 31. Shadow-set control: current set [3:0], previous set [9:6], exception set [15:12].

## Requirements
- R1: After reset, the redirect PC outputs are 0xBFC00000, 0xBFC00004 and 0xBFC00008, redirect_valid is 0, status reads 0x20000000 (CU1 set), exception base reads 0x80000000, and cause, EPC, bad address and shadow-set control read 0.
- R2: Every accepted request sets status EXL to 1, whatever its previous value, and produces redirect_valid high for exactly the one cycle after the accepting edge. Other status bits are kept.
- R3: Cause bits [6:2] take the request code. The codes are: 0 interrupt, 1 TLB modified, 2 TLB load/fetch, 3 TLB store, 4 load address error, 5 store address error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap. Cause bits outside the code, BD and CE fields are kept.
- R4: When next PC differs from PC+4, EPC = PC-4 and cause BD = 1. Otherwise EPC = PC and BD = 0.
- R5: Cause CE is 0 after every entry except code 11, which loads CE with the request's coprocessor number.
- R6: When EXL and BEV are both 0 before entry, the previous-set field takes the old current set and the current-set field takes the exception set. Otherwise the shadow-set control register is unchanged.
- R7: The default handler is exception base + 0x180. Code 12 with BEV = 1 goes to 0xBFC00200.
- R8: A refill request (qualifier set, code 2 or 3) goes to exception base + 0x000 when EXL was 0 before entry, and to base + 0x180 when EXL was 1. The qualifier is ignored for other codes.
- R9: Code 0 goes to exception base + 0x200 when cause IV = 1, and to base + 0x180 when IV = 0.
- R10: Codes 1 to 5 load the bad-address register with the faulting address. All other codes leave it unchanged.
- R11: With redirect_valid, redirect_npc = redirect_pc + 4 and redirect_nnpc = redirect_pc + 8.
- R12: A software write in the same cycle as an accepted request is discarded, including writes to registers that entry does not touch.
- R13: Outside entry cycles, a software write to an index updates that register at the clock edge, and a read returns it combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request accepted this cycle |
| exc_code | input | 5 | Cause code of the request |
| exc_refill | input | 1 | TLB refill qualifier for codes 2 and 3 |
| exc_addr | input | 32 | Faulting virtual address |
| exc_cop | input | 2 | Coprocessor number for code 11 |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_npc | input | 32 | Next PC after the faulting instruction |
| sw_we | input | 1 | Software register write strobe |
| sw_addr | input | 3 | Software register index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data (combinational) |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Handler address |
| redirect_npc | output | 32 | Handler address + 4 |
| redirect_nnpc | output | 32 | Handler address + 8 |

## Verification
Every entry result is registered, so all of them are due one clock after the accepting edge. The redirect strobe and addresses are sampled at the falling edge that follows that rising edge. Register contents are read back through the combinational read port in the same idle window, before any further write. The strobe is checked again one cycle later to confirm that it has dropped. Software writes land on the rising edge between two falling-edge drives and are modelled in the bench at that point, so the expected values never depend on process order at an edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam int CODE_W = 5;
  localparam int COP_W  = 2;
  localparam int SET_W  = 4;
  localparam int IDX_W  = 3;

  // status fields
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;
  // cause fields
  localparam int CA_EC_LO = 2;
  localparam int CA_IV    = 23;
  localparam int CA_CE_LO = 28;
  localparam int CA_BD    = 31;
  // shadow-set control fields
  localparam int SR_CUR_LO  = 0;
  localparam int SR_PREV_LO = 6;
  localparam int SR_EXC_LO  = 12;

  // register indexes
  localparam logic [IDX_W-1:0] IX_STATUS = 3'd0;
  localparam logic [IDX_W-1:0] IX_CAUSE  = 3'd1;
  localparam logic [IDX_W-1:0] IX_EPC    = 3'd2;
  localparam logic [IDX_W-1:0] IX_BADVA  = 3'd3;
  localparam logic [IDX_W-1:0] IX_SRS    = 3'd4;
  localparam logic [IDX_W-1:0] IX_EBASE  = 3'd5;

  // cause codes used for decisions
  localparam logic [CODE_W-1:0] EC_INT    = 5'd0;
  localparam logic [CODE_W-1:0] EC_TLB_LD = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLB_ST = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADE_ST = 5'd5;
  localparam logic [CODE_W-1:0] EC_CPU    = 5'd11;
  localparam logic [CODE_W-1:0] EC_OVF    = 5'd12;

  function automatic logic code_is_tlb(input logic [CODE_W-1:0] c);
    return (c == EC_TLB_LD) || (c == EC_TLB_ST);
  endfunction

  function automatic logic code_keeps_addr(input logic [CODE_W-1:0] c);
    return (c != EC_INT) && (c <= EC_ADE_ST);
  endfunction
endpackage

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
  import exc_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  word_t pc,
  input  word_t npc,
  output logic  in_delay,
  output word_t epc
);
  localparam word_t STEP = word_t'(INSN_BYTES);

  function automatic word_t back_one(input word_t a);
    return a - STEP;
  endfunction

  assign in_delay = (npc != pc + STEP);
  assign epc      = in_delay ? back_one(pc) : pc;
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int    INSN_BYTES   = 4,
  parameter word_t BOOT_OVF_VEC = 32'hBFC0_0200,
  parameter word_t OFF_GENERAL  = 32'h0000_0180,
  parameter word_t OFF_INTVEC   = 32'h0000_0200
) (
  input  logic [CODE_W-1:0] code,
  input  logic              refill,
  input  logic              exl,
  input  logic              bev,
  input  logic              iv,
  input  word_t             ebase,
  output word_t             handler,
  output word_t             handler_n,
  output word_t             handler_nn
);
  localparam word_t STEP = word_t'(INSN_BYTES);

  function automatic word_t pick_handler(
    input logic [CODE_W-1:0] c, input logic rf, input logic x,
    input logic b, input logic v, input word_t base);
    if (c == EC_OVF && b)                  return BOOT_OVF_VEC;
    else if (rf && code_is_tlb(c) && !x)   return base;
    else if (c == EC_INT && v)             return base + OFF_INTVEC;
    else                                   return base + OFF_GENERAL;
  endfunction

  assign handler    = pick_handler(code, refill, exl, bev, iv, ebase);
  assign handler_n  = handler + STEP;
  assign handler_nn = handler + (STEP << 1);
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter word_t EBASE_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry,
  input  logic [CODE_W-1:0] code,
  input  logic [COP_W-1:0]  cop,
  input  word_t             fault_addr,
  input  logic              in_delay,
  input  word_t             epc_val,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_addr,
  input  word_t             sw_wdata,
  output word_t             status_q,
  output word_t             cause_q,
  output word_t             epc_q,
  output word_t             badva_q,
  output word_t             srs_q,
  output word_t             ebase_q
);
  localparam word_t STATUS_RST = word_t'(1) << ST_CU1;

  logic swap_sets;
  logic take_addr;
  logic sw_apply;
  assign swap_sets = entry && !status_q[ST_EXL] && !status_q[ST_BEV];
  assign take_addr = entry && code_keeps_addr(code);
  assign sw_apply  = sw_we && !entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      badva_q  <= '0;
      srs_q    <= '0;
      ebase_q  <= EBASE_RST;
    end else if (entry) begin
      status_q[ST_EXL]               <= 1'b1;
      cause_q[CA_EC_LO +: CODE_W]    <= code;
      cause_q[CA_BD]                 <= in_delay;
      cause_q[CA_CE_LO +: COP_W]     <= (code == EC_CPU) ? cop : '0;
      epc_q                          <= epc_val;
      if (take_addr) badva_q <= fault_addr;
      if (swap_sets) begin
        srs_q[SR_PREV_LO +: SET_W] <= srs_q[SR_CUR_LO +: SET_W];
        srs_q[SR_CUR_LO +: SET_W]  <= srs_q[SR_EXC_LO +: SET_W];
      end
    end else if (sw_apply) begin
      case (sw_addr)
        IX_STATUS: status_q <= sw_wdata;
        IX_CAUSE:  cause_q  <= sw_wdata;
        IX_EPC:    epc_q    <= sw_wdata;
        IX_BADVA:  badva_q  <= sw_wdata;
        IX_SRS:    srs_q    <= sw_wdata;
        IX_EBASE:  ebase_q  <= sw_wdata;
        default: ;
      endcase
    end
  end

  AST_EXL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> status_q[ST_EXL]); // R2
  AST_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> cause_q[CA_EC_LO +: CODE_W] == $past(code)); // R3
  AST_BD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !in_delay) |=> (!cause_q[CA_BD] && epc_q == $past(epc_val))); // R4
  AST_CE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && code != EC_CPU) |=> cause_q[CA_CE_LO +: COP_W] == '0); // R5
  AST_SETS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && (status_q[ST_EXL] || status_q[ST_BEV])) |=> $stable(srs_q)); // R6
  AST_SETS_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_sets |=> srs_q[SR_PREV_LO +: SET_W] == $past(srs_q[SR_CUR_LO +: SET_W])); // R6
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !code_keeps_addr(code)) |=> $stable(badva_q)); // R10
  AST_SW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> $stable(ebase_q)); // R12
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int    INSN_BYTES   = 4,
  parameter word_t RESET_VEC    = 32'hBFC0_0000,
  parameter word_t BOOT_OVF_VEC = 32'hBFC0_0200,
  parameter word_t EBASE_RST    = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [4:0]        exc_code,
  input  logic              exc_refill,
  input  logic [31:0]       exc_addr,
  input  logic [1:0]        exc_cop,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       cur_npc,
  input  logic              sw_we,
  input  logic [2:0]        sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              redirect_valid,
  output logic [31:0]       redirect_pc,
  output logic [31:0]       redirect_npc,
  output logic [31:0]       redirect_nnpc
);
  localparam word_t STEP = word_t'(INSN_BYTES);

  word_t status_q, cause_q, epc_q, badva_q, srs_q, ebase_q;
  word_t epc_val, hnd, hnd_n, hnd_nn;
  logic  in_delay;

  exc_epc_calc #(.INSN_BYTES(INSN_BYTES)) u_epc (
    .pc(cur_pc), .npc(cur_npc), .in_delay(in_delay), .epc(epc_val)
  );

  exc_vector_sel #(.INSN_BYTES(INSN_BYTES), .BOOT_OVF_VEC(BOOT_OVF_VEC)) u_vec (
    .code(exc_code), .refill(exc_refill),
    .exl(status_q[ST_EXL]), .bev(status_q[ST_BEV]), .iv(cause_q[CA_IV]),
    .ebase(ebase_q), .handler(hnd), .handler_n(hnd_n), .handler_nn(hnd_nn)
  );

  exc_ctrl_regs #(.EBASE_RST(EBASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .entry(exc_valid), .code(exc_code),
    .cop(exc_cop), .fault_addr(exc_addr), .in_delay(in_delay),
    .epc_val(epc_val), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q),
    .badva_q(badva_q), .srs_q(srs_q), .ebase_q(ebase_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= RESET_VEC;
      redirect_npc   <= RESET_VEC + STEP;
      redirect_nnpc  <= RESET_VEC + (STEP << 1);
    end else begin
      redirect_valid <= exc_valid;
      if (exc_valid) begin
        redirect_pc   <= hnd;
        redirect_npc  <= hnd_n;
        redirect_nnpc <= hnd_nn;
      end
    end
  end

  always_comb begin
    case (sw_addr)
      IX_STATUS: sw_rdata = status_q;
      IX_CAUSE:  sw_rdata = cause_q;
      IX_EPC:    sw_rdata = epc_q;
      IX_BADVA:  sw_rdata = badva_q;
      IX_SRS:    sw_rdata = srs_q;
      IX_EBASE:  sw_rdata = ebase_q;
      default:   sw_rdata = '0;
    endcase
  end

  AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !redirect_valid); // R2
  AST_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> redirect_valid); // R2
  AST_SEQ_ADDRS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_npc - redirect_pc == STEP &&
                        redirect_nnpc - redirect_npc == STEP)); // R11
  AST_BOOT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code == EC_OVF && status_q[ST_BEV]) |=> redirect_pc == BOOT_OVF_VEC); // R7
endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/100ps
module exc_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_refill = 1'b0;
  logic [31:0] exc_addr = '0;
  logic [1:0]  exc_cop = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_npc = 32'd4;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc, redirect_npc, redirect_nnpc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_refill(exc_refill), .exc_addr(exc_addr), .exc_cop(exc_cop),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .redirect_npc(redirect_npc),
    .redirect_nnpc(redirect_nnpc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    sw_addr = a;
    #0.5;
    v = sw_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  // independent reference of the handler choice
  function automatic logic [31:0] ref_vec(input int code, input bit rf, input bit exl,
                                          input bit bev, input bit iv, input logic [31:0] eb);
    logic [31:0] off;
    if (code == 12 && bev) return 32'hBFC0_0200;
    off = 32'h180;
    if (code == 0 && iv) off = 32'h200;
    if (rf && (code == 2 || code == 3) && !exl) off = 32'h0;
    return eb + off;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int codes[12] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13};
    logic [31:0] v;
    int iter = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", redirect_pc, 32'hBFC0_0000);
    check("R1 npc", redirect_npc, 32'hBFC0_0004);
    check("R1 nnpc", redirect_nnpc, 32'hBFC0_0008);
    check("R1 valid", {31'b0, redirect_valid}, 32'd0);
    rd(0, v); check("R1 status", v, 32'h2000_0000);
    rd(1, v); check("R1 cause", v, 32'h0);
    rd(2, v); check("R1 epc", v, 32'h0);
    rd(3, v); check("R1 badva", v, 32'h0);
    rd(4, v); check("R1 srs", v, 32'h0);
    rd(5, v); check("R1 ebase", v, 32'h8000_0000);
    rst_n = 1'b1;

    // R13 software write / read
    wr(2, 32'hCAFE_0010);
    rd(2, v); check("R13 epc write", v, 32'hCAFE_0010);

    foreach (codes[ci]) begin
      for (int mode = 0; mode < 32; mode++) begin
        bit exl = mode[0], bev = mode[1], bd = mode[2], rf = mode[3], iv = mode[4];
        int code = codes[ci];
        logic [31:0] st0, ca0, srs0, eb0, pc, npc, fa, exp_ca, exp_srs, hv;
        logic [1:0] cop;
        logic [3:0] cs, ps, es;
        st0 = (32'(exl) << 1) | (32'(bev) << 22) | 32'h2000_0000 | 32'h0000_FF00;
        ca0 = (32'(iv) << 23) | 32'hB000_0300 | (32'h1F << 2);
        es = 4'(iter); cs = 4'(iter + 5); ps = 4'(iter + 9);
        srs0 = {16'h0, es, 2'b00, ps, 2'b00, cs};
        eb0 = 32'h8000_0000 + (32'(iter % 4) << 12);
        pc = 32'h0040_0100 + 32'(iter) * 8;
        npc = bd ? pc + 32'h40 : pc + 32'h4;
        fa = 32'h1000_0000 ^ (32'(iter) * 32'h111);
        cop = 2'(iter);
        wr(0, st0); wr(1, ca0); wr(2, 32'hDEAD_0000); wr(3, 32'h5555_0000);
        wr(4, srs0); wr(5, eb0);
        @(negedge clk);
        exc_valid = 1'b1; exc_code = 5'(code); exc_refill = rf; exc_addr = fa;
        exc_cop = cop; cur_pc = pc; cur_npc = npc;
        @(negedge clk);
        exc_valid = 1'b0;
        hv = ref_vec(code, rf, exl, bev, iv, eb0);
        check("R2 strobe", {31'b0, redirect_valid}, 32'd1);
        check("R7/R8/R9 handler", redirect_pc, hv);
        check("R11 npc", redirect_npc, hv + 4);
        check("R11 nnpc", redirect_nnpc, hv + 8);
        rd(0, v); check("R2 status", v, st0 | 32'h2);
        exp_ca = ca0;
        exp_ca[6:2] = 5'(code);
        exp_ca[31] = bd;
        exp_ca[29:28] = (code == 11) ? cop : 2'b00;
        rd(1, v); check("R3/R4/R5 cause", v, exp_ca);
        rd(2, v); check("R4 epc", v, bd ? pc - 4 : pc);
        rd(3, v); check("R10 badva", v, (code >= 1 && code <= 5) ? fa : 32'h5555_0000);
        exp_srs = (!exl && !bev) ? {16'h0, es, 2'b00, cs, 2'b00, es} : srs0;
        rd(4, v); check("R6 srs", v, exp_srs);
        @(negedge clk);
        check("R2 strobe drop", {31'b0, redirect_valid}, 32'd0);
        iter++;
      end
    end

    // R12 collision: software writes in the entry cycle are dropped
    wr(0, 32'h2000_0000); wr(5, 32'h8000_3000);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd8; exc_refill = 1'b0;
    cur_pc = 32'h0000_1000; cur_npc = 32'h0000_1004;
    sw_we = 1'b1; sw_addr = 3'd2; sw_wdata = 32'h1234_5678;
    @(negedge clk);
    exc_valid = 1'b0; sw_we = 1'b0;
    rd(2, v); check("R12 epc wins", v, 32'h0000_1000);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd9;
    sw_we = 1'b1; sw_addr = 3'd5; sw_wdata = 32'h8000_F000;
    @(negedge clk);
    exc_valid = 1'b0; sw_we = 1'b0;
    check("R12 handler uses old base", redirect_pc, 32'h8000_3180);
    rd(5, v); check("R12 ebase kept", v, 32'h8000_3000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule